// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. It produces an output pulse whose length is a programmed number of clock cycles. A pulse can be started by a rising edge on one trigger input or by a falling edge on a second trigger input. Each trigger input counts only while the other input sits at its idle level. An active-low clear input ends a running pulse and keeps new pulses from starting while it is held. A mode input selects between two behaviours. In retriggerable mode a new trigger restarts the full period. In non-retriggerable mode triggers are ignored while the output is high. Both the output and its complement are provided.

All three asynchronous control inputs (both triggers and clear) pass through the same synchronizer depth. As a result, trigger-to-output and clear-to-output latencies are equal and do not depend on the programmed width. For a second channel, instantiate the block a second time.

Top module: `mono_pulse`

## Requirements
- R1: A rising edge on `trig_rise` while `trig_fall` is high starts a pulse. With the default two-stage synchronizer, `q` goes high at the third rising clock edge after the input changes.
- R2: A falling edge on `trig_fall` while `trig_rise` is low starts a pulse, with the same latency as R1.
- R3: A rising edge on `trig_rise` is ignored while `trig_fall` is low. A falling edge on `trig_fall` is ignored while `trig_rise` is high. When both inputs move together, neither edge counts.
- R4: A pulse started from idle keeps `q` high for exactly `width` clock cycles. A trigger while `width` is 0 has no effect.
- R5: With `retrig` = 1, a valid trigger during a pulse reloads the period. `q` then stays high until `width` cycles after that trigger takes effect.
- R6: With `retrig` = 0, valid triggers that arrive while `q` is high are ignored, and the pulse ends `width` cycles after it began.
- R7: While `clear_n` is low (as seen after the synchronizer), `q` is driven low with the same latency as a trigger, and no pulse starts. A clear and a trigger taking effect in the same cycle result in no pulse.
- R8: `q_n` is always the inverse of `q`.
- R9: While `rst_n` is low, `q` is 0 and `q_n` is 1. The synchronizers reset to the idle levels: `trig_rise` low, `trig_fall` high, `clear_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_rise | input | 1 | Trigger on rising edge (idle low) |
| trig_fall | input | 1 | Trigger on falling edge (idle high) |
| clear_n | input | 1 | Active-low pulse abort and inhibit |
| retrig | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| width | input | 16 | Pulse length in clock cycles |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The hardest situations to reach are triggers that land while a pulse is running, and clears that coincide with a trigger. Both depend on the precise phase of input changes relative to the three-cycle pipeline. Directed cases place a second trigger a known number of cycles into a pulse under each mode, and drop clear at the same moment as a trigger edge. A long run of seeded random toggling of both triggers, clear, mode and small widths then hits overlapping and gated edges in many phases. Each cycle is compared against a bench model built from the requirements.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // Synchronized control levels, bundled so they travel one chain
  typedef struct packed {
    logic clr_n;
    logic fall;
    logic rise;
  } ctl_lvl_t;

  // Idle levels: rising trigger low, falling trigger high, clear asserted
  localparam ctl_lvl_t CTL_IDLE = '{clr_n: 1'b0, fall: 1'b1, rise: 1'b0};

  localparam int CTL_W = $bits(ctl_lvl_t);

endpackage

// File: rtl/mp_sync.sv
module mp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  // next-state: each stage takes its predecessor
  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= RST_VAL;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= chain_d[s];
      end
    end
  end

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/mp_trig_qual.sv
module mp_trig_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,   // synchronized leading-edge trigger level
  input  logic fall_i,   // synchronized trailing-edge trigger level
  output logic fire_o
);

  logic rise_q, fall_q;
  logic rise_d, fall_d;
  logic rise_edge, fall_edge;

  always_comb begin
    rise_d = rise_i;
    fall_d = fall_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b1;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  // Each edge is qualified by the other input's current idle level
  always_comb begin
    rise_edge = rise_i & ~rise_q & fall_i;
    fall_edge = ~fall_i & fall_q & ~rise_i;
    fire_o    = rise_edge | fall_edge;
  end

  // R3
  gate_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> !(rise_i && !fall_i));

endmodule

// File: rtl/mp_timer.sv
module mp_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          clr_n_i,
  input  logic          retrig_i,
  input  logic [CW-1:0] width_i,
  output logic          q_o
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;
  logic          running, load, cnt_en;

  always_comb begin
    running = (cnt_q != ZERO);
    load    = fire_i && (width_i != ZERO) && (retrig_i || !running);
    cnt_en  = !clr_n_i || load || running;
    cnt_d   = cnt_q;
    if (!clr_n_i) begin
      cnt_d = ZERO;
    end else if (load) begin
      cnt_d = width_i;
    end else if (running) begin
      cnt_d = cnt_q - ONE;
    end
    q_d = (cnt_d != ZERO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      q_q   <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q_o = q_q;

  // R4
  load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_q) |-> (cnt_q == $past(width_i)));

  // R5
  retrig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig_i && clr_n_i && fire_i && width_i != ZERO) |=> (cnt_q == $past(width_i)));

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_i && clr_n_i && running) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7
  clear_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |=> !q_q);

endmodule

// File: rtl/mono_pulse.sv
module mono_pulse
  import mp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise,
  input  logic             trig_fall,
  input  logic             clear_n,
  input  logic             retrig,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             q_n
);

  ctl_lvl_t ctl_raw, ctl_sync;
  logic     fire;
  logic     pulse;

  always_comb begin
    ctl_raw.rise  = trig_rise;
    ctl_raw.fall  = trig_fall;
    ctl_raw.clr_n = clear_n;
  end

  // One chain for all three controls keeps trigger and clear latency equal
  mp_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ctl_raw),
    .q_o   (ctl_sync)
  );

  mp_trig_qual u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (ctl_sync.rise),
    .fall_i (ctl_sync.fall),
    .fire_o (fire)
  );

  mp_timer #(
    .CW (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire),
    .clr_n_i  (ctl_sync.clr_n),
    .retrig_i (retrig),
    .width_i  (width),
    .q_o      (pulse)
  );

  assign q   = pulse;
  assign q_n = ~pulse;

  // R8
  comp_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_n != q);

endmodule

// File: tb/tb_mono_pulse.sv
`timescale 1ns/1ps
module tb_mono_pulse;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_rise, trig_fall, clear_n, retrig;
  logic [15:0] wid;
  logic        q, q_n;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    hi_cnt = 0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  mono_pulse dut (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .trig_fall(trig_fall),
    .clear_n(clear_n), .retrig(retrig), .width(wid), .q(q), .q_n(q_n)
  );

  // ---------------- reference model from the requirements -------------
  // h[i] = input triple sampled i+1 edges ago: {clr, fall, rise}
  logic [2:0] h0, h1, h2;
  int         m_cnt;

  function automatic logic model_fire(logic [2:0] c, logic [2:0] p);
    return (c[0] & ~p[0] & c[1]) | (~c[1] & p[1] & ~c[0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = 3'b010; h1 = 3'b010; h2 = 3'b010; m_cnt = 0;
    end else begin
      if (!h1[2]) m_cnt = 0;
      else if (model_fire(h1, h2) && wid != 0 && (retrig || m_cnt == 0)) m_cnt = int'(wid);
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      h2 = h1; h1 = h0; h0 = {clear_n, trig_fall, trig_rise};
    end
  end

  // per-cycle comparison and high-cycle counter, away from the clock edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      n_chk++;
      if (q !== (m_cnt != 0)) begin
        n_fail++;
        $display("FAIL %s model q=%0b expected %0b at %0t", cur_req, q, (m_cnt != 0), $time);
      end
      n_chk++;
      // R8
      if (q_n !== ~q) begin
        n_fail++;
        $display("FAIL R8 q_n=%0b expected %0b at %0t", q_n, ~q, $time);
      end
      if (q === 1'b1) hi_cnt++;
    end
  end

  // ---------------- helpers -------------------------------------------
  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle_inputs();
    trig_rise = 1'b0; trig_fall = 1'b1; clear_n = 1'b1;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  // ---------------- stimulus ------------------------------------------
  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; idle_inputs(); retrig = 1'b1; wid = 16'd5;
    step(3);
    // R9
    check("R9 q in reset", int'(q), 0);
    check("R9 q_n in reset", int'(q_n), 1);
    rst_n = 1'b1;
    step(4);

    // R1: latency and length
    cur_req = "R1"; hi_cnt = 0;
    trig_rise = 1'b1;
    step(2);
    check("R1 q before third edge", int'(q), 0);
    step(1);
    check("R1 q at third edge", int'(q), 1);
    step(20);
    check("R1 pulse length", hi_cnt, 5);
    trig_rise = 1'b0; step(5);

    // R2
    cur_req = "R2"; wid = 16'd7; hi_cnt = 0;
    trig_fall = 1'b0; step(25);
    check("R2 pulse length", hi_cnt, 7);

    // R3: rising edge while fall low, falling edge while rise high
    cur_req = "R3"; hi_cnt = 0;
    trig_rise = 1'b1; step(4);
    trig_fall = 1'b1; step(4);
    trig_fall = 1'b0; step(10);
    check("R3 gated edges", hi_cnt, 0);
    trig_fall = 1'b1; trig_rise = 1'b0; step(4);
    hi_cnt = 0;
    trig_rise = 1'b1; trig_fall = 1'b0; step(12);
    check("R3 simultaneous edges", hi_cnt, 0);
    idle_inputs(); step(5);

    // R4: zero width
    cur_req = "R4"; wid = 16'd0; hi_cnt = 0;
    trig_rise = 1'b1; step(12);
    check("R4 zero width", hi_cnt, 0);
    trig_rise = 1'b0; step(3);

    // R5: retrigger 5 cycles in, period 8 -> 13
    cur_req = "R5"; wid = 16'd8; retrig = 1'b1; hi_cnt = 0;
    trig_rise = 1'b1; step(2); trig_rise = 1'b0; step(3); trig_rise = 1'b1;
    step(30);
    check("R5 extended length", hi_cnt, 13);
    trig_rise = 1'b0; step(3);

    // R6: same stimulus, lockout -> 8
    cur_req = "R6"; retrig = 1'b0; hi_cnt = 0;
    trig_rise = 1'b1; step(2); trig_rise = 1'b0; step(3); trig_rise = 1'b1;
    step(30);
    check("R6 locked length", hi_cnt, 8);
    trig_rise = 1'b0; step(3);

    // R7: abort after 5 cycles, inhibit, same-cycle clear and trigger
    cur_req = "R7"; wid = 16'd20; retrig = 1'b1; hi_cnt = 0;
    trig_rise = 1'b1; step(5); clear_n = 1'b0;
    step(30);
    check("R7 aborted length", hi_cnt, 5);
    trig_rise = 1'b0; step(3); hi_cnt = 0;
    trig_rise = 1'b1; step(12);
    check("R7 inhibit while low", hi_cnt, 0);
    trig_rise = 1'b0; clear_n = 1'b1; step(4); hi_cnt = 0;
    trig_rise = 1'b1; clear_n = 1'b0; step(12);
    check("R7 clear wins same cycle", hi_cnt, 0);
    idle_inputs(); step(25);

    // random phase against the model
    cur_req = "R5/R6 random";
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1, 2: trig_rise = ~trig_rise;
        3, 4, 5: trig_fall = ~trig_fall;
        6:       clear_n   = ($urandom_range(0, 3) != 0);
        7:       retrig    = ~retrig;
        8:       wid       = 16'($urandom_range(0, 12));
        default: clear_n   = 1'b1;
      endcase
      step(int'($urandom_range(1, 6)));
    end
    idle_inputs(); step(30);
    check("R7 idle after random", int'(q), 0);

    finish_run();
  end

endmodule